// File: doc/BRIEF.md
# Serial Page-Flash Command Sequencer

This block turns high-level storage requests into complete command frames for a page-organised serial flash on an SPI link. A request names an operation (erase pages, program pages through the device's buffer, read a run of bytes, or erase the whole chip). It also carries a starting page number or byte offset and a count. The block builds the opcode and the three address bytes for each request. It streams any payload through a one-byte mode-0 shifter and brackets every frame with chip select.

Erase and program operations leave the device busy. The block finds out when the device is free by issuing status-read frames, spaced by a programmable idle gap, until the ready bit is set. One input selects where that polling happens. With the input low, the block waits after every erase or program page before going on. With the input high, it returns at once and polls on entry to the next command instead, and that includes reads. Multi-page requests walk consecutive pages. A page number becomes a byte address by a left shift of the page-size exponent.

Top module: `dflash_seq`

## Requirements
- R1: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the request completes. `done` is a single-cycle pulse, and `req_ready` is high again on the cycle after it.
- R2: SPI runs in mode 0. `spi_sck` idles low and is low whenever chip select changes. Each byte is eight clocks, most significant bit first. The block changes `spi_mosi` after falling edges and samples `spi_miso` on rising edges.
- R3: Page erase (`req_op`=0) sends 0x81 and then the 24-bit byte address, high byte first, all in one chip-select window. The address is the page number shifted left by `PAGE_SHIFT`.
- R4: Page program (`req_op`=1) sends 0x82, the 24-bit page address and exactly 2^`PAGE_SHIFT` bytes in one window. Each payload byte is taken from `wr_data`, and `wr_take` pulses once per byte taken.
- R5: Read (`req_op`=2) sends 0x0B, the 24-bit byte offset and one 0x00 dummy byte, then clocks in `req_count` bytes in the same window. Each byte appears on `rd_data` with a one-cycle `rd_valid`.
- R6: Chip erase (`req_op`=3) sends 0xC7, 0x94, 0x80, 0x9A in one window.
- R7: A status poll is its own window of two bytes, 0xD7 then 0xFF. Bit 7 of the second returned byte set means ready. Between two consecutive polls, chip select stays high for at least `POLL_GAP` cycles.
- R8: With `wait_before` low, every erase page, program page and chip erase is followed by polls until ready before the next page or `done`. Reads are not polled.
- R9: With `wait_before` high, every command, reads included, is preceded by polls until ready. `done` follows the last command without waiting, so the device may still be busy.
- R10: An erase or program request covers `req_count` consecutive pages starting at the given page, and a count of zero means one page. `done` is raised only after the last page has been issued.
- R11: Chip select stays high for at least 2*`HALF_DIV` cycles between any two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can take a request |
| req_op | input | 2 | 0 page erase, 1 page program, 2 read, 3 chip erase |
| req_addr | input | ADDR_W | Start page (erase/program) or byte offset (read) |
| req_count | input | CNT_W | Pages (erase/program) or bytes (read) |
| wait_before | input | 1 | 1: poll before each command; 0: poll after each erase/program |
| wr_data | input | 8 | Next program payload byte |
| wr_take | output | 1 | Pulse: `wr_data` was consumed |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Pulse: `rd_data` valid |
| done | output | 1 | Pulse: request complete |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The flash model keeps a busy timer that starts when an erase or program window closes. It flags any non-status command that lands while the timer runs. A sequencer that skipped polling in either placement, or forgot to poll before a read in the wait-before placement, is caught there. At `done` the bench expects the device to be idle in wait-after mode and still busy in wait-before mode, which exposes a swapped policy. Multi-page requests with counts of zero and three compare every address against the shifted page number, so an off-by-one page walk or a wrong shift shows up. Consecutive status frames are checked for their byte pattern and spacing, and read data is compared byte by byte against the model's address-derived contents.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef enum logic [1:0] {
    OP_PG_ERASE = 2'd0,
    OP_PG_PROG  = 2'd1,
    OP_RD       = 2'd2,
    OP_CHIP     = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    TK_ERASE,
    TK_PROG,
    TK_READ,
    TK_CHIP,
    TK_STAT
  } txn_kind_e;

  localparam logic [7:0] OPC_PG_ERASE = 8'h81;
  localparam logic [7:0] OPC_PG_PROG  = 8'h82;
  localparam logic [7:0] OPC_RD_FAST  = 8'h0B;
  localparam logic [7:0] OPC_STATUS   = 8'hD7;
  localparam logic [7:0] OPC_CHIP_0   = 8'hC7;
  localparam logic [7:0] OPC_CHIP_1   = 8'h94;
  localparam logic [7:0] OPC_CHIP_2   = 8'h80;
  localparam logic [7:0] OPC_CHIP_3   = 8'h9A;

  function automatic txn_kind_e kind_of(req_op_e op);
    case (op)
      OP_PG_ERASE: return TK_ERASE;
      OP_PG_PROG:  return TK_PROG;
      OP_RD:       return TK_READ;
      default:     return TK_CHIP;
    endcase
  endfunction

endpackage

// File: rtl/dfs_spi_byte.sv
module dfs_spi_byte #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = $clog2(HALF_DIV + 1);

  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sck     <= 1'b0;
      div     <= '0;
      bitn    <= '0;
      tx_sh   <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          tx_sh <= tx_byte;
          bitn  <= '0;
          div   <= '0;
        end
      end else if (div == DW'(HALF_DIV - 1)) begin
        div <= '0;
        sck <= ~sck;
        if (!sck) begin
          rx_byte <= {rx_byte[6:0], miso};
        end else if (bitn == 3'd7) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bitn  <= bitn + 3'd1;
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end else begin
        div <= div + DW'(1);
      end
    end
  end

  assign mosi = tx_sh[7];

  assert_sck_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);
  assert_done_ends_low_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sck && !busy));

endmodule

// File: rtl/dfs_frame.sv
module dfs_frame
  import dfs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  txn_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        idx,
  output logic [7:0]        hdr_byte,
  output logic [2:0]        hdr_len
);
  logic [23:0] a24;
  logic [7:0]  hb [8];

  assign a24 = 24'(addr);

  always_comb begin
    for (int i = 0; i < 8; i++) hb[i] = 8'h00;
    hdr_len = 3'd4;
    case (kind)
      TK_ERASE: begin
        hb[0] = OPC_PG_ERASE;
        hb[1] = a24[23:16]; hb[2] = a24[15:8]; hb[3] = a24[7:0];
      end
      TK_PROG: begin
        hb[0] = OPC_PG_PROG;
        hb[1] = a24[23:16]; hb[2] = a24[15:8]; hb[3] = a24[7:0];
      end
      TK_READ: begin
        hb[0] = OPC_RD_FAST;
        hb[1] = a24[23:16]; hb[2] = a24[15:8]; hb[3] = a24[7:0];
        hb[4] = 8'h00;
        hdr_len = 3'd5;
      end
      TK_CHIP: begin
        hb[0] = OPC_CHIP_0; hb[1] = OPC_CHIP_1;
        hb[2] = OPC_CHIP_2; hb[3] = OPC_CHIP_3;
      end
      default: begin
        hb[0] = OPC_STATUS; hb[1] = 8'hFF;
        hdr_len = 3'd2;
      end
    endcase
    hdr_byte = hb[idx];
  end

endmodule

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
  import dfs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int PAGE_SHIFT = 9,
  parameter int POLL_GAP   = 1250,
  parameter int CS_GAP     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              wait_before,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              cs_n,
  output txn_kind_e         kind_q,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [2:0]        frame_idx,
  input  logic [7:0]        hdr_byte,
  input  logic [2:0]        hdr_len,
  output logic              eng_start,
  output logic [7:0]        eng_tx,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);
  localparam int IW   = CNT_W + 1;
  localparam int TMAX = (POLL_GAP > CS_GAP) ? POLL_GAP : CS_GAP;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_POLL_IDLE, S_ISSUE, S_CS_LO, S_START,
    S_WAIT, S_CS_HI, S_AFTER, S_NEXT, S_FINISH
  } state_e;

  state_e            state;
  req_op_e           op_q;
  logic              mode_b;
  logic              poll_pre;
  logic              stat_rdy;
  logic [ADDR_W-1:0] page_q;
  logic [ADDR_W-1:0] off_q;
  logic [CNT_W-1:0]  remain_q;
  logic [IW-1:0]     idx_q;
  logic [IW-1:0]     total_q;
  logic [TW-1:0]     timer;
  logic [IW-1:0]     payload_len;
  logic              in_header;

  assign frame_addr = (kind_q == TK_READ) ? off_q : ADDR_W'(page_q << PAGE_SHIFT);
  assign frame_idx  = idx_q[2:0];
  assign in_header  = idx_q < IW'(hdr_len);

  always_comb begin
    case (kind_q)
      TK_PROG: payload_len = IW'(1) << PAGE_SHIFT;
      TK_READ: payload_len = IW'(remain_q);
      default: payload_len = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_PG_ERASE;
      kind_q    <= TK_STAT;
      mode_b    <= 1'b0;
      poll_pre  <= 1'b0;
      stat_rdy  <= 1'b0;
      page_q    <= '0;
      off_q     <= '0;
      remain_q  <= '0;
      idx_q     <= '0;
      total_q   <= '0;
      timer     <= '0;
      req_ready <= 1'b1;
      done      <= 1'b0;
      cs_n      <= 1'b1;
      wr_take   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      eng_start <= 1'b0;
      eng_tx    <= '0;
    end else begin
      done      <= 1'b0;
      wr_take   <= 1'b0;
      rd_valid  <= 1'b0;
      eng_start <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            op_q      <= req_op_e'(req_op);
            mode_b    <= wait_before;
            page_q    <= req_addr;
            off_q     <= req_addr;
            remain_q  <= (req_count == '0 && req_op_e'(req_op) != OP_RD) ?
                         CNT_W'(1) : req_count;
            timer     <= '0;
            poll_pre  <= 1'b1;
            state     <= wait_before ? S_POLL_IDLE : S_ISSUE;
          end
        end
        S_POLL_IDLE: begin
          if (timer == TW'(POLL_GAP - 1)) begin
            kind_q <= TK_STAT;
            state  <= S_CS_LO;
          end else begin
            timer <= timer + TW'(1);
          end
        end
        S_ISSUE: begin
          kind_q <= kind_of(op_q);
          state  <= S_CS_LO;
        end
        S_CS_LO: begin
          cs_n    <= 1'b0;
          idx_q   <= '0;
          total_q <= IW'(hdr_len) + payload_len;
          state   <= S_START;
        end
        S_START: begin
          eng_start <= 1'b1;
          if (in_header) begin
            eng_tx <= hdr_byte;
          end else if (kind_q == TK_PROG) begin
            eng_tx  <= wr_data;
            wr_take <= 1'b1;
          end else begin
            eng_tx <= 8'h00;
          end
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (eng_done) begin
            if (kind_q == TK_READ && !in_header) begin
              rd_valid <= 1'b1;
              rd_data  <= eng_rx;
            end
            stat_rdy <= eng_rx[7];
            if (idx_q + IW'(1) == total_q) begin
              cs_n  <= 1'b1;
              timer <= '0;
              state <= S_CS_HI;
            end else begin
              idx_q <= idx_q + IW'(1);
              state <= S_START;
            end
          end
        end
        S_CS_HI: begin
          if (timer == TW'(CS_GAP - 1)) state <= S_AFTER;
          else timer <= timer + TW'(1);
        end
        S_AFTER: begin
          timer <= '0;
          case (kind_q)
            TK_STAT: begin
              if (!stat_rdy)     state <= S_POLL_IDLE;
              else if (poll_pre) state <= S_ISSUE;
              else if (op_q == OP_CHIP) state <= S_FINISH;
              else               state <= S_NEXT;
            end
            TK_READ: state <= S_FINISH;
            default: begin
              if (mode_b) begin
                state <= (kind_q == TK_CHIP) ? S_FINISH : S_NEXT;
              end else begin
                poll_pre <= 1'b0;
                state    <= S_POLL_IDLE;
              end
            end
          endcase
        end
        S_NEXT: begin
          if (remain_q <= CNT_W'(1)) begin
            state <= S_FINISH;
          end else begin
            remain_q <= remain_q - CNT_W'(1);
            page_q   <= page_q + ADDR_W'(1);
            poll_pre <= 1'b1;
            timer    <= '0;
            state    <= mode_b ? S_POLL_IDLE : S_ISSUE;
          end
        end
        S_FINISH: begin
          done      <= 1'b1;
          req_ready <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_shift_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !cs_n);
  assert_wr_take_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> (!cs_n && kind_q == TK_PROG));
  assert_rd_valid_read_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> kind_q == TK_READ);
  assert_cs_gap_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);

endmodule

// File: rtl/dflash_seq.sv
module dflash_seq
  import dfs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int PAGE_SHIFT = 9,
  parameter int HALF_DIV   = 2,
  parameter int POLL_GAP   = 1250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              wait_before,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int CS_GAP = 2 * HALF_DIV;

  txn_kind_e         kind;
  logic [ADDR_W-1:0] frame_addr;
  logic [2:0]        frame_idx;
  logic [7:0]        hdr_byte;
  logic [2:0]        hdr_len;
  logic              eng_start, eng_busy, eng_done;
  logic [7:0]        eng_tx, eng_rx;

  dfs_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_SHIFT(PAGE_SHIFT),
    .POLL_GAP(POLL_GAP), .CS_GAP(CS_GAP)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_count(req_count), .wait_before(wait_before),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .cs_n(spi_cs_n), .kind_q(kind), .frame_addr(frame_addr),
    .frame_idx(frame_idx), .hdr_byte(hdr_byte), .hdr_len(hdr_len),
    .eng_start(eng_start), .eng_tx(eng_tx), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_rx(eng_rx)
  );

  dfs_frame #(.ADDR_W(ADDR_W)) u_frame (
    .kind(kind), .addr(frame_addr), .idx(frame_idx),
    .hdr_byte(hdr_byte), .hdr_len(hdr_len)
  );

  dfs_spi_byte #(.HALF_DIV(HALF_DIV)) u_spi (
    .clk(clk), .rst(rst), .start(eng_start), .tx_byte(eng_tx),
    .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

endmodule

// File: tb/test_dflash_seq.sv
module test_dflash_seq;
  localparam int HALF_DIV = 2, PAGE_SHIFT = 3, POLL_GAP = 40;
  localparam int BUSY_CYC = 400, CS_GAP = 2 * HALF_DIV;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, wait_before = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_count = '0;
  logic [7:0]  wr_data, rd_data;
  logic        wr_take, rd_valid, done, sck, cs_n, mosi;
  logic        miso = 1'b1;

  dflash_seq #(.PAGE_SHIFT(PAGE_SHIFT), .HALF_DIV(HALF_DIV), .POLL_GAP(POLL_GAP))
  i_dflash_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_count(req_count),
    .wait_before(wait_before), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  int checks = 0, errors = 0;

  function automatic void chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endfunction

  function automatic logic [7:0] mem_pat(int a);
    logic [23:0] x;
    x = a[23:0];
    return x[7:0] ^ {x[11:8], x[15:12]} ^ x[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] wpat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic string tag_of(logic [7:0] opc);
    case (opc)
      8'h81:   return "R3";
      8'h82:   return "R4";
      8'h0B:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // expected command list
  int eb0 [0:255];
  int eaddr [0:255];
  int elen [0:255];
  int ehead = 0, etail = 0;

  task automatic push(int b0, int a, int len);
    eb0[etail] = b0; eaddr[etail] = a & 24'hFFFFFF; elen[etail] = len;
    etail++;
  endtask

  // flash model
  int busy_cnt = 0, hi_len = 1000, cur_hi = 0;
  int nbits = 0, nbytes = 0, pmis = 0, spidx = 0;
  logic [7:0] bb [0:7];
  logic [7:0] shin = 0, rsh = 8'hFF;
  logic sck_d = 1'b0, cs_d = 1'b1, last_stat = 1'b0;

  task automatic end_txn();
    string t;
    if (bb[0] == 8'hD7) begin
      chk(nbytes == 2 && bb[1] == 8'hFF, "R7", "status frame length", nbytes, 2);
      if (last_stat) chk(cur_hi >= POLL_GAP, "R7", "poll spacing", cur_hi, POLL_GAP);
      last_stat = 1'b1;
    end else begin
      last_stat = 1'b0;
      t = tag_of(bb[0]);
      chk(busy_cnt == 0, "R8,R9", "command issued while busy", busy_cnt, 0);
      if (ehead == etail) begin
        chk(1'b0, "R10", "unexpected command", int'(bb[0]), 0);
      end else begin
        chk(int'(bb[0]) == eb0[ehead], t, "opcode", int'(bb[0]), eb0[ehead]);
        chk(int'({bb[1], bb[2], bb[3]}) == eaddr[ehead], t, "address bytes",
            int'({bb[1], bb[2], bb[3]}), eaddr[ehead]);
        chk(nbytes == elen[ehead], t, "frame length", nbytes, elen[ehead]);
        if (bb[0] == 8'h82) chk(pmis == 0, "R4", "payload mismatches", pmis, 0);
        if (bb[0] == 8'h0B) chk(bb[4] == 8'h00, "R5", "dummy byte", int'(bb[4]), 0);
        ehead++;
      end
      if (bb[0] == 8'h81 || bb[0] == 8'h82 || bb[0] == 8'hC7) busy_cnt = BUSY_CYC;
    end
  endtask

  always @(posedge clk) begin
    if (!rst) begin
      if (busy_cnt > 0) busy_cnt--;
      if (cs_n) hi_len++;
      if (cs_d && !cs_n) begin
        chk(hi_len >= CS_GAP, "R11", "chip select high cycles", hi_len, CS_GAP);
        chk(sck == 1'b0, "R2", "clock low at select", int'(sck), 0);
        cur_hi = hi_len; hi_len = 0; nbits = 0; nbytes = 0; pmis = 0;
        rsh = 8'hFF; miso <= 1'b1;
      end else if (!cs_n && !sck_d && sck) begin
        shin = {shin[6:0], mosi};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          if (nbytes < 8) bb[nbytes] = shin;
          if (bb[0] == 8'h82 && nbytes >= 4) begin
            if (shin != wpat(spidx)) pmis++;
            spidx++;
          end
          nbytes++;
          if (bb[0] == 8'hD7) rsh = (busy_cnt > 0) ? 8'h3C : 8'hBC;
          else if (bb[0] == 8'h0B && nbytes >= 5)
            rsh = mem_pat(int'({bb[1], bb[2], bb[3]}) + nbytes - 5);
          else rsh = 8'hFF;
        end
      end else if (!cs_n && sck_d && !sck) begin
        if (nbits != 0) rsh = {rsh[6:0], 1'b1};
        miso <= rsh[7];
      end
      if (!cs_d && cs_n) begin
        chk(sck == 1'b0, "R2", "clock low at deselect", int'(sck), 0);
        end_txn();
      end
    end
    sck_d <= sck;
    cs_d  <= cs_n;
  end

  // payload source and read sink
  int widx = 0, rd_base = 0, rd_cnt = 0, rd_err = 0;
  initial wr_data = wpat(0);
  always @(negedge clk) begin
    if (wr_take) begin widx++; wr_data = wpat(widx); end
    if (rd_valid) begin
      if (rd_data != mem_pat(rd_base + rd_cnt)) rd_err++;
      rd_cnt++;
    end
  end

  task automatic do_req(int op, int addr, int cnt, bit wb);
    int pages, n;
    if (!wb) while (busy_cnt > 0) @(negedge clk);
    pages = (cnt == 0) ? 1 : cnt;
    case (op)
      0: for (int p = 0; p < pages; p++) push(8'h81, (addr + p) << PAGE_SHIFT, 4);
      1: for (int p = 0; p < pages; p++)
           push(8'h82, (addr + p) << PAGE_SHIFT, 4 + (1 << PAGE_SHIFT));
      2: push(8'h0B, addr, 5 + cnt);
      default: push(8'hC7, 24'h94809A, 4);
    endcase
    @(negedge clk);
    rd_base = addr & 24'hFFFFFF; rd_cnt = 0; rd_err = 0;
    chk(req_ready, "R1", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_op = 2'(op); req_addr = 24'(addr);
    req_count = 16'(cnt); wait_before = wb;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "ready after accept", int'(req_ready), 0);
    n = 0;
    while (!done && n < 100000) begin @(negedge clk); n++; end
    if (op != 2) begin
      if (wb) chk(busy_cnt > 0, "R9", "device still busy at done", busy_cnt, 1);
      else    chk(busy_cnt == 0, "R8", "device idle at done", busy_cnt, 0);
    end
    chk(ehead == etail, "R10", "commands issued by done", ehead, etail);
    if (op == 2) begin
      chk(rd_cnt == cnt, "R5", "read bytes delivered", rd_cnt, cnt);
      chk(rd_err == 0, "R5", "read data mismatches", rd_err, 0);
    end
    @(negedge clk);
    chk(!done && req_ready, "R1", "done single and ready back",
        int'({done, req_ready}), 1);
  endtask

  initial begin
    int op, addr, cnt;
    bit wb;
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && !sck && req_ready && !done && !rd_valid && !wr_take,
        "R1", "reset state", int'({cs_n, sck, req_ready, done}), 4'b1010);
    // directed corners
    do_req(0, 16'h0123, 3, 1'b0);   // R3 R8 R10 multi-page erase, wait after
    do_req(0, 16'h0040, 0, 1'b1);   // R10 count zero, wait before
    do_req(2, 24'h00ABCD, 7, 1'b1); // R9 read polled while busy
    do_req(1, 16'h0201, 2, 1'b1);   // R4 program two pages
    do_req(1, 16'hFFFF, 1, 1'b0);   // R4 last page, wait after
    do_req(3, 0, 0, 1'b0);          // R6 chip erase, wait after
    do_req(3, 0, 0, 1'b1);          // R6 chip erase, wait before
    do_req(2, 24'hFFFFFE, 4, 1'b0); // R5 read across top
    for (int i = 0; i < 20; i++) begin
      op = int'($urandom % 4);
      wb = 1'($urandom % 2);
      if (op == 2) begin addr = int'($urandom & 24'hFFFFFF); cnt = 1 + int'($urandom % 20); end
      else begin addr = int'($urandom % 65536); cnt = int'($urandom % 4); end
      do_req(op, addr, cnt, wb);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule